// File: doc/BRIEF.md
# Sprite Scan-Line Pixel Shifter

This block produces the pixels of a single hardware sprite across one scan line. A fetch stage outside the block hands it the sprite's three data bytes for the line with a one-cycle load strobe. The block then watches a 9-bit horizontal beam counter. When the counter reaches the sprite's 9-bit X position, it emits the line one beam position per clock. Each output position carries a pixel-valid flag, a 4-bit color index and a flag that places the sprite behind background pixels.

The X position is assembled from the sprite's own 8-bit low register and one bit of a shared register that holds the ninth position bit of every sprite. The instance's sprite number selects that bit. Two modes change how the line is emitted. Horizontal doubling holds every pixel for two positions. Multicolor mode decodes bit pairs into one of three colors or transparency. Both mode bits are captured when the line starts. Enable, priority and the colors act on the output directly. Vertical line selection, memory fetch and mixing with the background belong to other blocks.

Top module: `sprite_line_shifter`

## Requirements
- R1: The start position is {x_msb_bits[SPR_IDX], x_low}. Only bit SPR_IDX of the shared register is used, so position 300 is low byte 44 with that bit set.
- R2: After a load, the first clock edge at which beam_x equals the start position starts the line. Output position 0 appears in the cycle after that edge, and one position follows per clock.
- R3: line_data[23] (bit 7 of the first byte) is the leftmost pixel, and lower bits follow toward bit 0.
- R4: With doubling and multicolor both off, the line lasts 24 positions. Position k shows bit 23-k: 1 gives pix_valid with own_color, and 0 is transparent.
- R5: With doubling on, each pixel lasts two positions and the line lasts 48 positions.
- R6: In multicolor mode, pair j (bits 23-2j and 22-2j) spans two pixel slots. Its codes are 00 transparent, 01 mc0_color, 10 own_color and 11 mc1_color. The line length stays 24 positions, or 48 with doubling.
- R7: While spr_enable is 0, pix_valid is 0 on every cycle.
- R8: pix_behind equals behind_bg on valid pixels and is 0 otherwise.
- R9: After the last position the block is idle. A further match of beam_x produces nothing until the next line_load.
- R10: After reset no line is armed and pix_valid is 0.
- R11: pix_color is 0 whenever pix_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one beam position per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| beam_x | input | 9 | Horizontal beam counter |
| x_low | input | 8 | Low 8 bits of this sprite's X position |
| x_msb_bits | input | 8 | Shared ninth-bit register, bit N for sprite N |
| spr_enable | input | 1 | Sprite enable |
| x_expand | input | 1 | Horizontal doubling |
| multicolor | input | 1 | Pixel-pair decoding |
| behind_bg | input | 1 | 1 = sprite behind background pixels |
| own_color | input | 4 | Sprite's own color index |
| mc0_color | input | 4 | Shared sprite multicolor 0 |
| mc1_color | input | 4 | Shared sprite multicolor 1 |
| line_load | input | 1 | Loads line_data and arms the start |
| line_data | input | 24 | Three data bytes, first byte in [23:16] |
| pix_valid | output | 1 | Non-transparent sprite pixel at this position |
| pix_color | output | 4 | Color index of the pixel |
| pix_behind | output | 1 | Pixel lies behind background |

## Verification
On every cycle the assertions check these properties: a match starts a run at position zero, the position counter stays inside the line length, the last position returns the block to idle with nothing armed, and the behind and color outputs are silent when no pixel shows. The bench's sweeps are the only evidence for the pixel pattern itself: bit ordering, pair decoding to the three colors, doubling of widths, the exact start cycle for many positions including those with the ninth bit set, and the fact that a second beam lap with no reload produces nothing.

// File: rtl/sprite_pkg.sv
package sprite_pkg;
  localparam int LINE_BITS = 24;

  // positions covered by one line
  function automatic int run_length(input logic expand);
    return expand ? 2 * LINE_BITS : LINE_BITS;
  endfunction

  // pixel code for beam offset pos: 00 transparent, 01 mc0, 10 own, 11 mc1
  function automatic logic [1:0] pixel_code(input logic [LINE_BITS-1:0] data,
                                            input int pos, input logic expand,
                                            input logic mc);
    int slot;
    logic [LINE_BITS-1:0] tmp;
    slot = expand ? pos / 2 : pos;
    if (mc) begin
      tmp = data >> (LINE_BITS - 2 - 2 * (slot / 2));
      return tmp[1:0];
    end
    tmp = data >> (LINE_BITS - 1 - slot);
    return tmp[0] ? 2'b10 : 2'b00;
  endfunction
endpackage

// File: rtl/sprite_xpos_match.sv
module sprite_xpos_match #(
  parameter int POS_W   = 9,
  parameter int NUM_SPR = 8,
  parameter int SPR_IDX = 0
) (
  input  logic [POS_W-2:0]   x_low,
  input  logic [NUM_SPR-1:0] x_msb_bits,
  input  logic [POS_W-1:0]   beam_x,
  output logic [POS_W-1:0]   x_pos,
  output logic               hit
);
  assign x_pos = {x_msb_bits[SPR_IDX], x_low};
  assign hit   = (beam_x == x_pos);
endmodule

// File: rtl/sprite_run_ctrl.sv
module sprite_run_ctrl
  import sprite_pkg::*;
#(
  parameter int CNT_W = $clog2(2 * LINE_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_load,
  input  logic [LINE_BITS-1:0] line_data,
  input  logic                 hit,
  input  logic                 x_expand,
  input  logic                 multicolor,
  output logic                 active,
  output logic [1:0]           code
);
  logic                 armed;
  logic [CNT_W-1:0]     pos;
  logic                 exp_l, mc_l;
  logic [LINE_BITS-1:0] sreg;
  logic                 at_last, start_evt;

  assign at_last   = active && (int'(pos) == run_length(exp_l) - 1);
  assign start_evt = !active && armed && hit;
  assign code      = active ? pixel_code(sreg, int'(pos), exp_l, mc_l) : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      active <= 1'b0;
      pos    <= '0;
      exp_l  <= 1'b0;
      mc_l   <= 1'b0;
      sreg   <= '0;
    end else if (line_load) begin
      sreg   <= line_data;
      armed  <= 1'b1;
      active <= 1'b0;
      pos    <= '0;
    end else if (active) begin
      if (at_last) active <= 1'b0;
      else         pos    <= pos + 1'b1;
    end else if (start_evt) begin
      active <= 1'b1;
      armed  <= 1'b0;
      pos    <= '0;
      exp_l  <= x_expand;
      mc_l   <= multicolor;
    end
  end

  // R2
  start_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !line_load) |=> (active && pos == '0));
  // R5
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (int'(pos) < run_length(exp_l)));
  // R9
  run_end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_last && !line_load) |=> (!active && !armed));
  // R10
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!active && !armed));
endmodule

// File: rtl/sprite_pixel_decode.sv
module sprite_pixel_decode #(
  parameter int COLOR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         code,
  input  logic               active,
  input  logic               spr_enable,
  input  logic               behind_bg,
  input  logic [COLOR_W-1:0] own_color,
  input  logic [COLOR_W-1:0] mc0_color,
  input  logic [COLOR_W-1:0] mc1_color,
  output logic               pix_valid,
  output logic [COLOR_W-1:0] pix_color,
  output logic               pix_behind
);
  always_comb begin
    pix_valid = spr_enable && active && (code != 2'b00);
    pix_color = '0;
    if (pix_valid) begin
      case (code)
        2'b01:   pix_color = mc0_color;
        2'b10:   pix_color = own_color;
        default: pix_color = mc1_color;
      endcase
    end
    pix_behind = pix_valid && behind_bg;
  end

  // R7
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (spr_enable && active));
  // R8
  behind_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_behind |-> pix_valid);
  // R11
  idle_color_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> (pix_color == '0));
endmodule

// File: rtl/sprite_line_shifter.sv
module sprite_line_shifter
  import sprite_pkg::*;
#(
  parameter int POS_W   = 9,
  parameter int NUM_SPR = 8,
  parameter int SPR_IDX = 0,
  parameter int COLOR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [POS_W-1:0]     beam_x,
  input  logic [POS_W-2:0]     x_low,
  input  logic [NUM_SPR-1:0]   x_msb_bits,
  input  logic                 spr_enable,
  input  logic                 x_expand,
  input  logic                 multicolor,
  input  logic                 behind_bg,
  input  logic [COLOR_W-1:0]   own_color,
  input  logic [COLOR_W-1:0]   mc0_color,
  input  logic [COLOR_W-1:0]   mc1_color,
  input  logic                 line_load,
  input  logic [LINE_BITS-1:0] line_data,
  output logic                 pix_valid,
  output logic [COLOR_W-1:0]   pix_color,
  output logic                 pix_behind
);
  logic [POS_W-1:0] x_pos;
  logic             hit;
  logic             active;
  logic [1:0]       code;

  sprite_xpos_match #(.POS_W(POS_W), .NUM_SPR(NUM_SPR), .SPR_IDX(SPR_IDX)) u_match (
    .x_low(x_low), .x_msb_bits(x_msb_bits), .beam_x(beam_x),
    .x_pos(x_pos), .hit(hit)
  );

  sprite_run_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .line_load(line_load), .line_data(line_data),
    .hit(hit), .x_expand(x_expand), .multicolor(multicolor),
    .active(active), .code(code)
  );

  sprite_pixel_decode #(.COLOR_W(COLOR_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .code(code), .active(active),
    .spr_enable(spr_enable), .behind_bg(behind_bg),
    .own_color(own_color), .mc0_color(mc0_color), .mc1_color(mc1_color),
    .pix_valid(pix_valid), .pix_color(pix_color), .pix_behind(pix_behind)
  );

  // R1
  msb_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_pos[POS_W-1] == x_msb_bits[SPR_IDX]) && (x_pos[POS_W-2:0] == x_low));
endmodule

// File: tb/sprite_line_shifter_test.sv
module sprite_line_shifter_test;
  localparam int CLK_PERIOD = 10;
  localparam int SPR = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] beam_x = '0;
  logic [7:0] x_low = '0;
  logic [7:0] x_msb_bits = '0;
  logic spr_enable = 1'b0, x_expand = 1'b0, multicolor = 1'b0, behind_bg = 1'b0;
  logic [3:0] own_color = 4'h1, mc0_color = 4'h7, mc1_color = 4'hC;
  logic line_load = 1'b0;
  logic [23:0] line_data = '0;
  logic pix_valid, pix_behind;
  logic [3:0] pix_color;

  int checks = 0;
  int errors = 0;

  // model state
  bit m_armed = 0, m_active = 0;
  int m_pos = 0;
  bit m_exp = 0, m_mc = 0;
  logic [23:0] m_data = '0;
  int valid_count;
  int first_beam;
  int last_beam;

  always #(CLK_PERIOD/2) clk = ~clk;

  sprite_line_shifter #(.SPR_IDX(SPR)) uut (
    .clk(clk), .rst_n(rst_n), .beam_x(beam_x), .x_low(x_low),
    .x_msb_bits(x_msb_bits), .spr_enable(spr_enable), .x_expand(x_expand),
    .multicolor(multicolor), .behind_bg(behind_bg), .own_color(own_color),
    .mc0_color(mc0_color), .mc1_color(mc1_color), .line_load(line_load),
    .line_data(line_data), .pix_valid(pix_valid), .pix_color(pix_color),
    .pix_behind(pix_behind)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compare outputs with model (called at negedge)
  task automatic compare_outputs();
    int p, code, e_col;
    bit e_valid;
    string tag;
    code = 0;
    if (m_active) begin
      p = m_exp ? m_pos / 2 : m_pos;
      if (m_mc) code = int'((m_data >> (22 - 2 * (p / 2))) & 24'h3);
      else code = ((m_data >> (23 - p)) & 24'h1) != 0 ? 2 : 0;
    end
    e_valid = spr_enable && m_active && code != 0;
    e_col = !e_valid ? 0 : (code == 1 ? int'(mc0_color) : code == 2 ? int'(own_color) : int'(mc1_color));
    tag = !spr_enable ? "R7" : (m_mc ? "R6" : (m_exp ? "R5" : "R4"));
    check(tag, int'(pix_valid), int'(e_valid), "valid");
    check(e_valid ? tag : "R11", int'(pix_color), e_col, "color");
    check("R8", int'(pix_behind), int'(e_valid && behind_bg), "behind");
    if (pix_valid) begin
      if (valid_count == 0) first_beam = last_beam;
      valid_count++;
    end
  endtask

  task automatic load_line(input logic [23:0] d);
    @(negedge clk);
    compare_outputs();
    line_load = 1'b1;
    line_data = d;
    m_data = d; m_armed = 1; m_active = 0; m_pos = 0;
    @(negedge clk);
    line_load = 1'b0;
  endtask

  task automatic run_line(input int xpos, input bit en, input bit expd, input bit mc,
                          input bit beh, input logic [23:0] d, input int ncyc);
    x_low = xpos[7:0];
    x_msb_bits = xpos[8] ? (8'h1 << SPR) : ~(8'h1 << SPR);
    spr_enable = en; x_expand = expd; multicolor = mc; behind_bg = beh;
    load_line(d);
    valid_count = 0;
    first_beam = -1;
    for (int i = 0; i < ncyc; i++) begin
      if (i > 0) begin
        @(negedge clk);
      end
      compare_outputs();
      beam_x = 9'(i % 512);
      last_beam = i % 512;
      if (m_active) begin
        if (m_pos == (m_exp ? 48 : 24) - 1) m_active = 0;
        else m_pos++;
      end else if (m_armed && (i % 512) == xpos) begin
        m_active = 1; m_armed = 0; m_pos = 0; m_exp = expd; m_mc = mc;
      end
    end
    @(negedge clk);
    compare_outputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int xs[8] = '{0, 1, 300, 127, 255, 256, 400, 511};
    logic [23:0] pats[2] = '{24'hF05AC3, 24'h1BE496};
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", int'(pix_valid), 0, "valid in reset");
    rst_n = 1'b1;
    spr_enable = 1'b1;
    x_low = 8'd0;
    repeat (4) begin
      @(negedge clk);
      beam_x = 9'd0;
      check("R10", int'(pix_valid), 0, "valid after reset, unarmed");
    end

    // R1 R2 R3: position 300 from low 44 plus shared bit, single leftmost pixel
    run_line(300, 1, 0, 0, 0, 24'h800000, 400);
    check("R1", first_beam, 300, "start beam of first pixel");
    check("R3", valid_count, 1, "single leftmost pixel count");

    // R3: rightmost bit is last of 24 positions
    run_line(100, 1, 0, 0, 0, 24'h000001, 200);
    check("R3", first_beam, 123, "position of bit 0");

    // R9: two beam laps, one load: one run only
    run_line(20, 1, 0, 0, 1, 24'hFFFFFF, 1100);
    check("R9", valid_count, 24, "valid positions over two laps");

    // R5: doubled full line length
    run_line(50, 1, 1, 0, 0, 24'hFFFFFF, 200);
    check("R5", valid_count, 48, "doubled line length");

    // R6: all four pair codes
    run_line(60, 1, 0, 1, 0, 24'h1B1B1B, 200);
    check("R6", valid_count, 18, "multicolor visible positions");

    // sweep: positions x modes x patterns, plus enable off
    foreach (xs[xi]) begin
      for (int mode = 0; mode < 4; mode++) begin
        for (int pt = 0; pt < 2; pt++) begin
          run_line(xs[xi], 1, mode[0], mode[1], xi[0], pats[pt], 580);
        end
      end
      // R7: disabled, every cycle checked
      run_line(xs[xi], 0, xi[1], xi[0], 1, 24'hFFFFFF, 580);
      check("R7", valid_count, 0, "disabled sprite visible positions");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule